// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block translates instruction fetch addresses next to an instruction cache. Each lookup presents an effective address. While virtual mode is in force, a direct-mapped table of 4 kB page translations is consulted. A matching entry returns a real address. A missing entry, or a privileged page fetched from problem state, returns a fetch-failed indication so that a later stage can start a page walk or raise a fault. While virtual mode is off, the effective address is used directly as the real address.

The table slot is chosen by XOR-folding three consecutive page-number fields, so that nearby and widely separated pages both spread across the table. A page-walk unit installs page table entries through a write port. Entries that could never allow execution are refused. An invalidate port clears one hashed slot without comparing the tag. A separate flush input clears the whole table at once. The virtual and privilege modes are latched only when the fetch stream is redirected.

Top module: `itlb_xlate`

## Requirements
- R1: After reset every entry is invalid, the mode is real and privileged, and `rsp_valid_o`, `hit_o` and `fetch_fail_o` are 0. A virtual lookup made before any install fails.
- R2: The slot index is `ea[17:12] ^ ea[23:18] ^ ea[29:24]`. Two pages with the same index share one slot, so installing the second evicts the first. Pages with different indices coexist.
- R3: A virtual lookup whose slot is valid and whose stored tag equals `ea[63:18]` responds with `hit_o`=1, `fetch_fail_o`=0 and `ra_o = {pte[55:12], ea[11:0]}`, where pte is the installed entry.
- R4: A virtual lookup that finds its slot invalid, or finds a different tag in it, responds with `fetch_fail_o`=1 and `hit_o`=0.
- R5: If the matching entry was installed with PTE bit 3 set and the privilege mode is 0 (problem state), the lookup responds with `fetch_fail_o`=1. With privilege mode 1 the same lookup hits.
- R6: The virtual and privilege modes are loaded from `redir_virt_i`/`redir_priv_i` only in a cycle with `redirect_i`=1. A lookup in that same cycle already uses the new values. In other cycles, changes on those inputs have no effect.
- R7: An install whose PTE has bit 0 (execute) or bit 8 (reference) clear is refused. It neither creates an entry nor disturbs the one already in the slot.
- R8: With virtual mode 0, a lookup responds with `hit_o`=1, `fetch_fail_o`=0 and `ra_o = ea[55:0]`, whatever the table holds.
- R9: A single invalidate clears the slot its address hashes to, whatever tag the slot holds. An install to the same slot in the same cycle takes effect.
- R10: `flush_all_i` invalidates every entry in one cycle and overrides an install or invalidate in the same cycle.
- R11: Each request (`req_i`=1) produces exactly one response with `rsp_valid_o`=1 on the next clock edge. Without a request, `rsp_valid_o`, `hit_o` and `fetch_fail_o` are 0. `hit_o` and `fetch_fail_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_i | input | 1 | Fetch redirect; loads the mode flags |
| redir_virt_i | input | 1 | Virtual mode value loaded on redirect |
| redir_priv_i | input | 1 | Privilege mode value loaded on redirect (1 = privileged) |
| req_i | input | 1 | Lookup request |
| ea_i | input | 64 | Lookup effective address |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| hit_o | output | 1 | Translation succeeded |
| fetch_fail_o | output | 1 | Translation failed (miss or privilege) |
| ra_o | output | 56 | Real address |
| wr_i | input | 1 | Install strobe |
| wr_ea_i | input | 64 | Effective address of the page being installed |
| wr_pte_i | input | 64 | Page table entry to install |
| inv_i | input | 1 | Single-slot invalidate strobe |
| inv_ea_i | input | 64 | Address whose hashed slot is invalidated |
| flush_all_i | input | 1 | Invalidate every entry |

## Verification
The bench uses the default parameters: 64 slots, three 6-bit fold fields, a 64-bit effective address and a 56-bit real address. With these widths, aliasing pages can be built by flipping the same bit pattern in two fold fields. That makes slot sharing, tag-blind invalidation and non-destructive refusal directly observable. Because the full page number is visible, the bench can also predict every real address, including the upper real-address bits taken from the entry.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    // Fixed positions inside a page table entry
    localparam int PTE_EXEC_BIT = 0;
    localparam int PTE_PRIV_BIT = 3;
    localparam int PTE_REF_BIT  = 8;

    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_FAULT = 2'd2
    } lk_kind_e;

endpackage

// File: rtl/itlb_fold_hash.sv
module itlb_fold_hash #(
    parameter int IDX_W = 6,
    parameter int FOLDS = 3,
    localparam int HASH_W = IDX_W * FOLDS
) (
    input  logic [HASH_W-1:0] page_i,
    output logic [IDX_W-1:0]  idx_o
);

    logic [IDX_W-1:0] acc [FOLDS+1];

    assign acc[0] = '0;

    for (genvar k = 0; k < FOLDS; k++) begin : g_fold
        assign acc[k+1] = acc[k] ^ page_i[k*IDX_W +: IDX_W];
    end

    assign idx_o = acc[FOLDS];

endmodule

// File: rtl/itlb_entry_store.sv
module itlb_entry_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 46,
    parameter int RPN_W   = 44,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             inv_i,
    input  logic [IDX_W-1:0] inv_idx_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [RPN_W-1:0] wr_rpn_i,
    input  logic             wr_priv_i,
    input  logic             wr_exec_i,
    input  logic             wr_ref_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic [TAG_W-1:0] rd_tag_o,
    output logic [RPN_W-1:0] rd_rpn_o,
    output logic             rd_priv_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][RPN_W-1:0] rpn;
        logic [ENTRIES-1:0]            priv;
    } store_t;

    store_t st_d, st_q;
    logic   accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_i && wr_exec_i && wr_ref_i;
        if (flush_i) begin
            st_d.valid = '0;
        end else begin
            if (inv_i) begin
                st_d.valid[inv_idx_i] = 1'b0;
            end
            if (accept) begin
                st_d.valid[wr_idx_i] = 1'b1;
                st_d.tag[wr_idx_i]   = wr_tag_i;
                st_d.rpn[wr_idx_i]   = wr_rpn_i;
                st_d.priv[wr_idx_i]  = wr_priv_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = st_q.valid[rd_idx_i];
    assign rd_tag_o   = st_q.tag[rd_idx_i];
    assign rd_rpn_o   = st_q.rpn[rd_idx_i];
    assign rd_priv_o  = st_q.priv[rd_idx_i];

    // R10: a flush leaves no entry valid
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> st_q.valid == '0);

    // R7: a refused install with nothing else going on leaves the valid bits alone
    assert_refuse_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !(wr_exec_i && wr_ref_i) && !flush_i && !inv_i)
        |=> st_q.valid == $past(st_q.valid));

    // R9: a lone invalidate clears its slot whatever the tag
    assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_i && !wr_i && !flush_i) |=> !st_q.valid[$past(inv_idx_i)]);

endmodule

// File: rtl/itlb_match.sv
module itlb_match
    import itlb_pkg::*;
#(
    parameter int EA_W       = 64,
    parameter int RA_W       = 56,
    parameter int PAGE_SHIFT = 12,
    parameter int TAG_LO     = 18,
    localparam int TAG_W     = EA_W - TAG_LO,
    localparam int RPN_W     = RA_W - PAGE_SHIFT
) (
    input  logic             req_i,
    input  logic             virt_i,
    input  logic             priv_i,
    input  logic [EA_W-1:0]  ea_i,
    input  logic             ent_valid_i,
    input  logic [TAG_W-1:0] ent_tag_i,
    input  logic [RPN_W-1:0] ent_rpn_i,
    input  logic             ent_priv_i,
    output lk_kind_e         kind_o,
    output logic [RA_W-1:0]  ra_o
);

    logic tag_eq;

    assign tag_eq = ent_valid_i && (ent_tag_i == ea_i[EA_W-1:TAG_LO]);

    always_comb begin
        kind_o = LK_NONE;
        ra_o   = '0;
        if (req_i) begin
            if (!virt_i) begin
                kind_o = LK_HIT;
                ra_o   = ea_i[RA_W-1:0];
            end else if (tag_eq && !(ent_priv_i && !priv_i)) begin
                kind_o = LK_HIT;
                ra_o   = {ent_rpn_i, ea_i[PAGE_SHIFT-1:0]};
            end else begin
                kind_o = LK_FAULT;
            end
        end
    end

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int FOLDS      = 3,
    parameter int EA_W       = 64,
    parameter int RA_W       = 56,
    parameter int PTE_W      = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect_i,
    input  logic             redir_virt_i,
    input  logic             redir_priv_i,
    input  logic             req_i,
    input  logic [EA_W-1:0]  ea_i,
    output logic             rsp_valid_o,
    output logic             hit_o,
    output logic             fetch_fail_o,
    output logic [RA_W-1:0]  ra_o,
    input  logic             wr_i,
    input  logic [EA_W-1:0]  wr_ea_i,
    input  logic [PTE_W-1:0] wr_pte_i,
    input  logic             inv_i,
    input  logic [EA_W-1:0]  inv_ea_i,
    input  logic             flush_all_i
);

    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int HASH_W  = IDX_W * FOLDS;
    localparam int TAG_LO  = PAGE_SHIFT + IDX_W;
    localparam int TAG_W   = EA_W - TAG_LO;
    localparam int RPN_W   = RA_W - PAGE_SHIFT;

    typedef struct packed {
        logic            virt;
        logic            priv;
        logic            rsp_valid;
        logic            hit;
        logic            fail;
        logic [RA_W-1:0] ra;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] rd_idx, wr_idx, inv_idx;
    logic             virt_eff, priv_eff;
    logic             ent_valid, ent_priv;
    logic [TAG_W-1:0] ent_tag;
    logic [RPN_W-1:0] ent_rpn;
    lk_kind_e         kind;
    logic [RA_W-1:0]  lk_ra;

    // Bits of the install and invalidate ports that carry no information here
    logic unused_port_bits;
    assign unused_port_bits = ^{wr_ea_i[PAGE_SHIFT-1:0], wr_pte_i[PTE_W-1:RA_W],
                                wr_pte_i[PAGE_SHIFT-1:PTE_REF_BIT+1],
                                wr_pte_i[PTE_REF_BIT-1:PTE_PRIV_BIT+1],
                                wr_pte_i[PTE_PRIV_BIT-1:PTE_EXEC_BIT+1],
                                inv_ea_i[EA_W-1:PAGE_SHIFT+HASH_W],
                                inv_ea_i[PAGE_SHIFT-1:0]};

    itlb_fold_hash #(.IDX_W(IDX_W), .FOLDS(FOLDS)) u_hash_rd (
        .page_i (ea_i[PAGE_SHIFT +: HASH_W]),
        .idx_o  (rd_idx)
    );

    itlb_fold_hash #(.IDX_W(IDX_W), .FOLDS(FOLDS)) u_hash_wr (
        .page_i (wr_ea_i[PAGE_SHIFT +: HASH_W]),
        .idx_o  (wr_idx)
    );

    itlb_fold_hash #(.IDX_W(IDX_W), .FOLDS(FOLDS)) u_hash_inv (
        .page_i (inv_ea_i[PAGE_SHIFT +: HASH_W]),
        .idx_o  (inv_idx)
    );

    itlb_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .RPN_W(RPN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_all_i),
        .inv_i      (inv_i),
        .inv_idx_i  (inv_idx),
        .wr_i       (wr_i),
        .wr_idx_i   (wr_idx),
        .wr_tag_i   (wr_ea_i[EA_W-1:TAG_LO]),
        .wr_rpn_i   (wr_pte_i[RA_W-1:PAGE_SHIFT]),
        .wr_priv_i  (wr_pte_i[PTE_PRIV_BIT]),
        .wr_exec_i  (wr_pte_i[PTE_EXEC_BIT]),
        .wr_ref_i   (wr_pte_i[PTE_REF_BIT]),
        .rd_idx_i   (rd_idx),
        .rd_valid_o (ent_valid),
        .rd_tag_o   (ent_tag),
        .rd_rpn_o   (ent_rpn),
        .rd_priv_o  (ent_priv)
    );

    assign virt_eff = redirect_i ? redir_virt_i : st_q.virt;
    assign priv_eff = redirect_i ? redir_priv_i : st_q.priv;

    itlb_match #(
        .EA_W(EA_W), .RA_W(RA_W), .PAGE_SHIFT(PAGE_SHIFT), .TAG_LO(TAG_LO)
    ) u_match (
        .req_i       (req_i),
        .virt_i      (virt_eff),
        .priv_i      (priv_eff),
        .ea_i        (ea_i),
        .ent_valid_i (ent_valid),
        .ent_tag_i   (ent_tag),
        .ent_rpn_i   (ent_rpn),
        .ent_priv_i  (ent_priv),
        .kind_o      (kind),
        .ra_o        (lk_ra)
    );

    always_comb begin
        st_d           = st_q;
        st_d.virt      = virt_eff;
        st_d.priv      = priv_eff;
        st_d.rsp_valid = (kind != LK_NONE);
        st_d.hit       = (kind == LK_HIT);
        st_d.fail      = (kind == LK_FAULT);
        st_d.ra        = lk_ra;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o  = st_q.rsp_valid;
    assign hit_o        = st_q.hit;
    assign fetch_fail_o = st_q.fail;
    assign ra_o         = st_q.ra;

    // R11: one response per request, on the next edge
    assert_req_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_valid_o);

    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rsp_valid_o && !hit_o && !fetch_fail_o);

    assert_hit_fail_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && fetch_fail_o));

    // R8: real mode passes the address through
    assert_real_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !virt_eff) |=> hit_o && !fetch_fail_o && ra_o == $past(ea_i[RA_W-1:0]));

    // R6: mode flags hold between redirects
    assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_i |=> $stable(st_q.virt) && $stable(st_q.priv));

endmodule

// File: tb/itlb_xlate_bench.sv
module itlb_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_i = 1'b0, redir_virt_i = 1'b0, redir_priv_i = 1'b1;
    logic        req_i = 1'b0;
    logic [63:0] ea_i = '0;
    logic        rsp_valid_o, hit_o, fetch_fail_o;
    logic [55:0] ra_o;
    logic        wr_i = 1'b0;
    logic [63:0] wr_ea_i = '0, wr_pte_i = '0;
    logic        inv_i = 1'b0;
    logic [63:0] inv_ea_i = '0;
    logic        flush_all_i = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic        hit;
        logic [55:0] ra;
    } exp_t;

    exp_t  exp_q[$];
    string nm_q[$];
    exp_t  cur;
    string cur_nm;

    always #2 clk = ~clk;

    itlb_xlate u_itlb_xlate (
        .clk(clk), .rst_n(rst_n),
        .redirect_i(redirect_i), .redir_virt_i(redir_virt_i), .redir_priv_i(redir_priv_i),
        .req_i(req_i), .ea_i(ea_i),
        .rsp_valid_o(rsp_valid_o), .hit_o(hit_o), .fetch_fail_o(fetch_fail_o), .ra_o(ra_o),
        .wr_i(wr_i), .wr_ea_i(wr_ea_i), .wr_pte_i(wr_pte_i),
        .inv_i(inv_i), .inv_ea_i(inv_ea_i), .flush_all_i(flush_all_i)
    );

    function automatic logic [63:0] mkpte(input logic [43:0] rpn, input logic ex,
                                          input logic rf, input logic pv);
        return ({20'd0, rpn} << 12) | (64'(rf) << 8) | (64'(pv) << 3) | 64'(ex);
    endfunction

    task automatic chk(input logic ok, input string nm, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", nm, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected response", 64'(rsp_valid_o), 64'd0);
            end else begin
                cur    = exp_q.pop_front();
                cur_nm = nm_q.pop_front();
                chk(hit_o == cur.hit && fetch_fail_o == !cur.hit, cur_nm,
                    {hit_o, fetch_fail_o}, {cur.hit, !cur.hit});
                if (cur.hit)
                    chk(ra_o == cur.ra, {cur_nm, " ra"}, 64'(ra_o), 64'(cur.ra));
            end
        end
    end

    task automatic clr();
        req_i = 1'b0; redirect_i = 1'b0; wr_i = 1'b0; inv_i = 1'b0; flush_all_i = 1'b0;
    endtask

    task automatic look(input logic [63:0] ea, input logic rd, input logic v,
                        input logic p, input logic eh, input logic [55:0] era,
                        input string nm);
        @(negedge clk);
        clr();
        req_i = 1'b1; ea_i = ea; redirect_i = rd;
        if (rd) begin
            redir_virt_i = v;
            redir_priv_i = p;
        end
        exp_q.push_back('{hit: eh, ra: era});
        nm_q.push_back(nm);
    endtask

    task automatic put(input logic [63:0] ea, input logic [63:0] pte, input logic fl);
        @(negedge clk);
        clr();
        wr_i = 1'b1; wr_ea_i = ea; wr_pte_i = pte; flush_all_i = fl;
    endtask

    task automatic kill(input logic [63:0] ea);
        @(negedge clk);
        clr();
        inv_i = 1'b1; inv_ea_i = ea;
    endtask

    task automatic idle();
        @(negedge clk);
        clr();
    endtask

    logic [63:0] pa, pb, pd, pf;
    localparam logic [63:0] EA_A  = 64'h00AB_CDEF_1234_5678;
    localparam logic [63:0] EA_B2 = EA_A ^ (64'd1 << 12) ^ (64'd1 << 18);
    localparam logic [63:0] EA_D  = EA_A ^ (64'd1 << 24);
    localparam logic [63:0] EA_F  = EA_A ^ (64'd2 << 12);
    localparam logic [63:0] EA_G  = EA_A ^ (64'd4 << 12);
    localparam logic [63:0] EA_E  = 64'h0000_7700_0000_0ABC;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs
        chk(!rsp_valid_o && !hit_o && !fetch_fail_o, "R1 reset outputs",
            {rsp_valid_o, hit_o, fetch_fail_o}, 64'd0);

        // R8: real mode after reset passes through
        look(64'hFFEE_1122_3344_5566, 0, 0, 0, 1, 56'hEE_1122_3344_5566, "R8 real after reset");
        // R1/R4: empty table misses in virtual mode (redirect cycle uses new mode, R6)
        look(EA_A, 1, 1, 1, 0, '0, "R1 R4 empty miss");

        pa = mkpte(44'h0_0012_3456, 1, 1, 0);
        put(EA_A, pa, 0);
        look(EA_A, 0, 0, 0, 1, {pa[55:12], EA_A[11:0]}, "R3 hit A");
        look(EA_A ^ 64'h0FF, 0, 0, 0, 1, {pa[55:12], EA_A[11:0] ^ 12'h0FF}, "R3 hit A offset");
        look(64'h0000_0000_4000_0000, 0, 0, 0, 0, '0, "R4 miss other page");
        look(EA_B2, 0, 0, 0, 0, '0, "R4 R2 alias tag mismatch");

        // R2: alias evicts, different slot coexists
        pb = mkpte(44'hA_BCDE_F012, 1, 1, 0);
        put(EA_B2, pb, 0);
        pd = mkpte(44'h5_5555_0001, 1, 1, 0);
        put(EA_D, pd, 0);
        look(EA_B2, 0, 0, 0, 1, {pb[55:12], EA_B2[11:0]}, "R2 alias installed");
        look(EA_A, 0, 0, 0, 0, '0, "R2 alias evicted A");
        look(EA_D, 0, 0, 0, 1, {pd[55:12], EA_D[11:0]}, "R2 other slot D");

        // R7: refused installs
        put(EA_E, mkpte(44'h1, 0, 1, 0), 0);
        look(EA_E, 0, 0, 0, 0, '0, "R7 no exec refused");
        put(EA_E, mkpte(44'h1, 1, 0, 0), 0);
        look(EA_E, 0, 0, 0, 0, '0, "R7 no ref refused");
        put(EA_A, mkpte(44'h2, 1, 0, 0), 0);
        look(EA_B2, 0, 0, 0, 1, {pb[55:12], EA_B2[11:0]}, "R7 refused keeps slot");

        // R5: privileged page
        pf = mkpte(44'h3_0303_0303, 1, 1, 1);
        put(EA_F, pf, 0);
        look(EA_F, 0, 0, 0, 1, {pf[55:12], EA_F[11:0]}, "R5 priv page privileged");
        look(EA_F, 1, 1, 0, 0, '0, "R5 priv page problem state");
        look(EA_B2, 0, 0, 0, 1, {pb[55:12], EA_B2[11:0]}, "R5 normal page problem state");

        // R6: flag inputs ignored without redirect
        idle();
        redir_priv_i = 1'b1;
        redir_virt_i = 1'b0;
        look(EA_F, 0, 0, 0, 0, '0, "R6 no redirect keeps mode");
        look(EA_F, 1, 1, 1, 1, {pf[55:12], EA_F[11:0]}, "R6 redirect same cycle");

        // R9: tag-blind invalidate of B2's slot
        kill(EA_B2 ^ (64'd3 << 18) ^ (64'd3 << 24));
        look(EA_B2, 0, 0, 0, 0, '0, "R9 slot invalidated");
        look(EA_D, 0, 0, 0, 1, {pd[55:12], EA_D[11:0]}, "R9 other slot kept");

        // R10: flush beats simultaneous install
        put(EA_G, mkpte(44'h7, 1, 1, 0), 1);
        look(EA_G, 0, 0, 0, 0, '0, "R10 install overridden");
        look(EA_D, 0, 0, 0, 0, '0, "R10 D flushed");
        look(EA_F, 0, 0, 0, 0, '0, "R10 F flushed");

        // R8: real mode ignores empty table
        look(EA_D, 1, 0, 0, 1, EA_D[55:0], "R8 real passthrough");

        idle();
        idle();
        // R11: no response without request
        chk(!rsp_valid_o && !hit_o && !fetch_fail_o, "R11 idle quiet",
            {rsp_valid_o, hit_o, fetch_fail_o}, 64'd0);
        chk(exp_q.size() == 0, "R11 all requests answered", 64'(exp_q.size()), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule